// File: doc/BRIEF.md
# Gyro Sensor SPI Register Slave

This block stands in for a three-axis rate sensor on an SPI bus so that a bus controller can be exercised against it without real silicon. It runs on the system clock and treats the SPI pins as asynchronous inputs. The pins pass through a synchronizer, and the block then detects clock edges in the system clock domain. The SPI bus uses mode 0: data moves MSB first, MOSI is sampled on rising SCLK, and MISO changes after falling SCLK. Each SCLK level must last at least 8 system clock cycles.

A transaction opens with a command byte that sets the direction, the address stepping and a 6-bit start address. Data bytes follow until chip select rises. The register map holds a fixed identity code, six writable configuration bytes, and a read-only window with temperature, status and three 16-bit axis samples. A one-cycle load pulse on a parallel port captures the samples. The status byte tracks unread data and data that was overwritten before it was read.

Top module: `gyro_spi_slave`

## Requirements
- R1: Command byte: bit 7 = 1 selects read and 0 selects write; bit 6 = 1 enables address stepping; bits 5:0 give the start address. In a read, the byte at the current address is shifted out MSB first during each following byte.
- R2: Address 0x0F always reads 0xD4, and writes to it have no effect.
- R3: Addresses 0x20 to 0x24 and 0x2E are read/write and return the last value written. They read 0x00 after reset.
- R4: A high cycle of `smp_load` captures the samples. Afterwards 0x26 reads the temperature, and 0x28/0x29, 0x2A/0x2B and 0x2C/0x2D read X, Y and Z, low byte first.
- R5: Status at 0x27: bits 0, 1 and 2 flag new X, Y and Z data. Bit 3 is set when all three are set. Bits 4, 5 and 6 flag X, Y and Z overrun. Bit 7 is set when all three overrun bits are set. A load sets bits 0 to 2.
- R6: With stepping enabled, the address rises by one after every data byte, for both reads and writes.
- R7: With stepping disabled, every data byte of the transaction uses the same address.
- R8: Completing a read of an axis high byte (0x29, 0x2B or 0x2D) clears that axis's new-data and overrun bits. Reading a low byte clears nothing.
- R9: A load while an axis's new-data bit is still set raises that axis's overrun bit.
- R10: Raising chip select abandons any partial byte. A cut-off write byte is not stored, and the next transaction starts with a command byte.
- R11: Unmapped addresses read 0x00. Writes to unmapped addresses and to 0x26 through 0x2D are ignored.
- R12: MISO is low while chip select is high, and the status and sample registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (asynchronous) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from controller |
| spi_miso | output | 1 | Serial data to controller |
| smp_load | input | 1 | One-cycle strobe capturing a sample set |
| smp_temp | input | 8 | Temperature byte to capture |
| smp_x | input | 16 | X-axis sample |
| smp_y | input | 16 | Y-axis sample |
| smp_z | input | 16 | Z-axis sample |

## Verification
A wrong bit counter or a stale first-byte flag shows up one byte later. The controller then sees either a data byte taken as a command or a command byte written into a register, and the next readback exposes it. An address register that fails to step, or steps when it should not, surfaces at the second data byte of a burst as a repeated or skipped value. Errors in the new-data and overrun flags only appear when the status byte is next read. The bench therefore reads status right after each load and right after each axis read.

// File: rtl/gyro_spi_pkg.sv
package gyro_spi_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 6;
  localparam int N_AXES = 3;

  localparam logic [REG_AW-1:0] A_IDENT    = 6'h0F;
  localparam logic [REG_AW-1:0] A_CFG_BASE = 6'h20;
  localparam int                N_CFG      = 5;
  localparam logic [REG_AW-1:0] A_TEMP     = 6'h26;
  localparam logic [REG_AW-1:0] A_STAT     = 6'h27;
  localparam logic [REG_AW-1:0] A_AXIS_BASE = 6'h28;
  localparam logic [REG_AW-1:0] A_QCFG     = 6'h2E;
  localparam logic [BYTE_W-1:0] IDENT_CODE = 8'hD4;
endpackage

// File: rtl/gyro_spi_sync.sv
module gyro_spi_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_in;
      end else begin : g_next
        assign src = stg[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= src;
      end
    end
  endgenerate

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/gyro_spi_frame.sv
module gyro_spi_frame #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_done,
  output logic              step_mode,
  output logic              cs_act,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic              miso
);
  logic              sclk_q, sclk_q_nxt;
  logic              cmd_ph, cmd_ph_nxt;
  logic              rd_mode, rd_mode_nxt;
  logic              step_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [BIT_W-1:0]  bit_nxt;
  logic [DATA_W-1:0] rx_sr, rx_nxt, rx_full;
  logic [DATA_W-1:0] tx_sr, tx_nxt;
  logic              fetch, fetch_nxt;
  logic              rise, fall, byte_end;

  always_comb begin
    cs_act   = ~cs_n_s;
    rise     = sclk_s & ~sclk_q;
    fall     = ~sclk_s & sclk_q;
    rx_full  = {rx_sr[DATA_W-2:0], mosi_s};
    byte_end = cs_act & rise & (bit_cnt == BIT_W'(DATA_W-1));

    sclk_q_nxt  = sclk_s;
    cmd_ph_nxt  = cmd_ph;
    rd_mode_nxt = rd_mode;
    step_nxt    = step_mode;
    addr_nxt    = cur_addr;
    bit_nxt     = bit_cnt;
    rx_nxt      = rx_sr;
    tx_nxt      = tx_sr;
    fetch_nxt   = fetch;

    if (!cs_act) begin
      cmd_ph_nxt  = 1'b1;
      rd_mode_nxt = 1'b0;
      bit_nxt     = '0;
      tx_nxt      = '0;
      fetch_nxt   = 1'b0;
    end else begin
      if (rise) begin
        rx_nxt  = rx_full;
        bit_nxt = bit_cnt + 1'b1;
      end
      if (fetch) begin
        tx_nxt    = rd_data;
        fetch_nxt = 1'b0;
      end else if (fall && bit_cnt != '0) begin
        tx_nxt = {tx_sr[DATA_W-2:0], 1'b0};
      end
      if (byte_end) begin
        if (cmd_ph) begin
          cmd_ph_nxt  = 1'b0;
          rd_mode_nxt = rx_full[DATA_W-1];
          step_nxt    = rx_full[DATA_W-2];
          addr_nxt    = rx_full[ADDR_W-1:0];
          fetch_nxt   = rx_full[DATA_W-1];
        end else begin
          if (step_mode) addr_nxt = cur_addr + 1'b1;
          fetch_nxt = rd_mode;
        end
      end
    end

    wr_en   = byte_end & ~cmd_ph & ~rd_mode;
    rd_done = byte_end & ~cmd_ph & rd_mode;
    wr_data = rx_full;
    miso    = cs_act & tx_sr[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cmd_ph    <= 1'b1;
      rd_mode   <= 1'b0;
      step_mode <= 1'b0;
      cur_addr  <= '0;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      fetch     <= 1'b0;
    end else begin
      sclk_q    <= sclk_q_nxt;
      cmd_ph    <= cmd_ph_nxt;
      rd_mode   <= rd_mode_nxt;
      step_mode <= step_nxt;
      cur_addr  <= addr_nxt;
      bit_cnt   <= bit_nxt;
      rx_sr     <= rx_nxt;
      tx_sr     <= tx_nxt;
      fetch     <= fetch_nxt;
    end
  end
endmodule

// File: rtl/gyro_spi_regs.sv
module gyro_spi_regs
  import gyro_spi_pkg::*;
#(
  parameter int SMP_W = 16,
  localparam int N_OUT = N_AXES * SMP_W / BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [REG_AW-1:0]       addr,
  input  logic                    wr_en,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    rd_done,
  input  logic                    smp_load,
  input  logic [BYTE_W-1:0]       smp_temp,
  input  logic [N_AXES*SMP_W-1:0] smp_axes,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [N_AXES-1:0]       new_flags,
  output logic [N_AXES-1:0]       ovr_flags
);
  logic [BYTE_W-1:0] cfg [N_CFG];
  logic [BYTE_W-1:0] qcfg;
  logic [BYTE_W-1:0] temp_r;
  logic [BYTE_W-1:0] out_b [N_OUT];
  logic [N_CFG-1:0]  cfg_we;
  logic              qcfg_we;
  logic [N_AXES-1:0] clr;
  logic [N_AXES-1:0] new_nxt, ovr_nxt;
  logic [BYTE_W-1:0] stat_byte;

  always_comb begin
    for (int i = 0; i < N_CFG; i++)
      cfg_we[i] = wr_en && (addr == REG_AW'(A_CFG_BASE + i));
    qcfg_we = wr_en && (addr == A_QCFG);
    for (int k = 0; k < N_AXES; k++) begin
      clr[k] = rd_done && (addr == REG_AW'(A_AXIS_BASE + 2*k + 1));
      if (smp_load) begin
        new_nxt[k] = 1'b1;
        ovr_nxt[k] = ovr_flags[k] | new_flags[k];
      end else if (clr[k]) begin
        new_nxt[k] = 1'b0;
        ovr_nxt[k] = 1'b0;
      end else begin
        new_nxt[k] = new_flags[k];
        ovr_nxt[k] = ovr_flags[k];
      end
    end
    stat_byte = {&ovr_flags, ovr_flags, &new_flags, new_flags};
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_IDENT) rd_data = IDENT_CODE;
    if (addr == A_QCFG)  rd_data = qcfg;
    if (addr == A_TEMP)  rd_data = temp_r;
    if (addr == A_STAT)  rd_data = stat_byte;
    for (int i = 0; i < N_CFG; i++)
      if (addr == REG_AW'(A_CFG_BASE + i)) rd_data = cfg[i];
    for (int j = 0; j < N_OUT; j++)
      if (addr == REG_AW'(A_AXIS_BASE + j)) rd_data = out_b[j];
  end

  generate
    for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg[i] <= '0;
        else if (cfg_we[i]) cfg[i] <= wr_data;
      end
    end
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_b[j] <= '0;
        else if (smp_load) out_b[j] <= smp_axes[j*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcfg      <= '0;
      temp_r    <= '0;
      new_flags <= '0;
      ovr_flags <= '0;
    end else begin
      if (qcfg_we)  qcfg   <= wr_data;
      if (smp_load) temp_r <= smp_temp;
      new_flags <= new_nxt;
      ovr_flags <= ovr_nxt;
    end
  end
endmodule

// File: rtl/gyro_spi_slave.sv
module gyro_spi_slave
  import gyro_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SMP_W = 16,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             smp_load,
  input  logic [7:0]       smp_temp,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z
);
  logic [1:0]        rst_pipe;
  logic              rst_n_sync;
  logic [2:0]        pins_s;
  logic [REG_AW-1:0] cur_addr;
  logic              wr_en, rd_done, step_mode, cs_act;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [BIT_W-1:0]  bit_cnt;
  logic [N_AXES-1:0] new_flags, ovr_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  gyro_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_in  ({spi_cs_n, spi_sclk, spi_mosi}),
    .d_out (pins_s)
  );

  gyro_spi_frame #(.DATA_W(BYTE_W), .ADDR_W(REG_AW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .sclk_s    (pins_s[1]),
    .cs_n_s    (pins_s[2]),
    .mosi_s    (pins_s[0]),
    .rd_data   (rd_data),
    .cur_addr  (cur_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_done   (rd_done),
    .step_mode (step_mode),
    .cs_act    (cs_act),
    .bit_cnt   (bit_cnt),
    .miso      (spi_miso)
  );

  gyro_spi_regs #(.SMP_W(SMP_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .addr      (cur_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_done   (rd_done),
    .smp_load  (smp_load),
    .smp_temp  (smp_temp),
    .smp_axes  ({smp_z, smp_y, smp_x}),
    .rd_data   (rd_data),
    .new_flags (new_flags),
    .ovr_flags (ovr_flags)
  );
endmodule

// File: rtl/gyro_spi_chk.sv
module gyro_spi_chk #(
  parameter int ADDR_W = 6,
  parameter int BIT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic [BIT_W-1:0]  bit_cnt,
  input logic              wr_en,
  input logic              rd_done,
  input logic              step_mode,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              smp_load,
  input logic [2:0]        new_flags,
  input logic [2:0]        ovr_flags
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_done})); // R1

  AST_LOAD_SETS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    smp_load |=> (new_flags == 3'b111)); // R5

  AST_OVERRUN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_load && new_flags[0]) |=> ovr_flags[0]); // R9

  AST_ABANDON_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0)); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_done) && step_mode && cs_act) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1))); // R6

  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_done) && !step_mode) |=> $stable(cur_addr)); // R7
endmodule

bind gyro_spi_slave gyro_spi_chk #(.ADDR_W(6), .BIT_W(3)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .cs_act    (cs_act),
  .bit_cnt   (bit_cnt),
  .wr_en     (wr_en),
  .rd_done   (rd_done),
  .step_mode (step_mode),
  .cur_addr  (cur_addr),
  .smp_load  (smp_load),
  .new_flags (new_flags),
  .ovr_flags (ovr_flags)
);

// File: tb/tb_gyro_spi_slave.sv
module tb_gyro_spi_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NV = 16;

  // {command, write data, expected read}
  localparam logic [23:0] VEC [NV] = '{
    {8'h8F, 8'h00, 8'hD4},  // R2 identity
    {8'h20, 8'h5A, 8'h00},  // R3 write cfg
    {8'h24, 8'hC3, 8'h00},
    {8'h2E, 8'h40, 8'h00},
    {8'h0F, 8'h11, 8'h00},  // R2 write ignored
    {8'hA0, 8'h00, 8'h5A},  // R3 readback
    {8'hA4, 8'h00, 8'hC3},
    {8'hAE, 8'h00, 8'h40},
    {8'h8F, 8'h00, 8'hD4},  // R2
    {8'hA1, 8'h00, 8'h00},  // R3 reset value
    {8'h10, 8'hFF, 8'h00},  // R11 unmapped write
    {8'h90, 8'h00, 8'h00},  // R11
    {8'hBF, 8'h00, 8'h00},  // R11
    {8'h26, 8'h77, 8'h00},  // R11 read-only window
    {8'hA6, 8'h00, 8'h00},
    {8'hA7, 8'h00, 8'h00}   // R12 status after reset
  };
  localparam int VREQ [NV] = '{2, 3, 3, 3, 2, 3, 3, 3, 2, 3, 11, 11, 11, 11, 11, 12};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic smp_load = 1'b0;
  logic [7:0] smp_temp = '0;
  logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;

  logic [7:0] txb [16];
  logic [7:0] rxb [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gyro_spi_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .smp_load(smp_load),
    .smp_temp(smp_temp), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      r[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_begin();
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic xfer(input int n);
    cs_begin();
    for (int k = 0; k < n; k++) send_bits(txb[k], 8, rxb[k]);
    cs_end();
  endtask

  task automatic rd1(input logic [7:0] cmd, output logic [7:0] v);
    txb[0] = cmd; txb[1] = 8'h00;
    xfer(2);
    v = rxb[1];
  endtask

  task automatic load(input logic [7:0] t, input logic [15:0] x, input logic [15:0] y,
                      input logic [15:0] z);
    smp_temp = t; smp_x = x; smp_y = y; smp_z = z;
    smp_load = 1'b1;
    wait_clk(1);
    smp_load = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, dummy;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(6);
    check("R12 miso idle after reset", {7'd0, miso}, 8'h00);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      txb[0] = VEC[i][23:16];
      txb[1] = VEC[i][15:8];
      xfer(2);
      if (VEC[i][23]) check($sformatf("R%0d R1 vector %0d", VREQ[i], i), rxb[1], VEC[i][7:0]);
    end
    check("R12 miso low with cs high", {7'd0, miso}, 8'h00);

    // R7: fixed address read and write
    txb[0] = 8'hA0; txb[1] = 0; txb[2] = 0; txb[3] = 0;
    xfer(4);
    for (int k = 1; k < 4; k++) check("R7 repeated read", rxb[k], 8'h5A);
    txb[0] = 8'h21; txb[1] = 8'h11; txb[2] = 8'h22;
    xfer(3);
    rd1(8'hA1, v); check("R7 last write wins", v, 8'h22);
    rd1(8'hA2, v); check("R7 neighbour untouched", v, 8'h00);

    // R6: stepped write then stepped read
    txb[0] = 8'h62; txb[1] = 8'hA1; txb[2] = 8'hA2;
    xfer(3);
    txb[0] = 8'hE0;
    for (int k = 1; k < 6; k++) txb[k] = 8'h00;
    xfer(6);
    check("R6 burst 0x20", rxb[1], 8'h5A);
    check("R6 burst 0x21", rxb[2], 8'h22);
    check("R6 burst 0x22", rxb[3], 8'hA1);
    check("R6 burst 0x23", rxb[4], 8'hA2);
    check("R6 burst 0x24", rxb[5], 8'hC3);

    // R4 R5: sample window burst
    load(8'h19, 16'h1234, 16'hABCD, 16'h8001);
    txb[0] = 8'hE6;
    for (int k = 1; k < 9; k++) txb[k] = 8'h00;
    xfer(9);
    check("R4 temp", rxb[1], 8'h19);
    check("R5 status new data", rxb[2], 8'h0F);
    check("R4 x low", rxb[3], 8'h34);
    check("R4 x high", rxb[4], 8'h12);
    check("R4 y low", rxb[5], 8'hCD);
    check("R4 y high", rxb[6], 8'hAB);
    check("R4 z low", rxb[7], 8'h01);
    check("R4 z high", rxb[8], 8'h80);
    rd1(8'hA7, v); check("R8 status cleared by reads", v, 8'h00);

    // R9 overrun, R8 per-axis clear
    load(8'h2A, 16'h5678, 16'h9ABC, 16'h0102);
    load(8'h2B, 16'h5679, 16'h9ABD, 16'h0103);
    rd1(8'hA7, v); check("R9 overrun all axes", v, 8'hFF);
    rd1(8'hA9, v); check("R4 x high after reload", v, 8'h56);
    rd1(8'hA7, v); check("R8 x flags cleared", v, 8'h66);
    rd1(8'hA8, v); check("R8 low byte value", v, 8'h79);
    rd1(8'hA7, v); check("R8 low byte clears nothing", v, 8'h66);

    // R10: abandoned partial data byte
    cs_begin();
    send_bits(8'h24, 8, dummy);
    send_bits(8'hFF, 4, dummy);
    cs_end();
    rd1(8'hA4, v); check("R10 partial write dropped", v, 8'hC3);
    cs_begin();
    send_bits(8'hA0, 3, dummy);
    cs_end();
    rd1(8'h8F, v); check("R10 framing restarts", v, 8'hD4);
    check("R12 miso low at end", {7'd0, miso}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule